// File: doc/BRIEF.md
# Sixteen-bit add/subtract unit with condition flags

This block is the arithmetic slice of a small RISC co-processor. It takes two 16-bit register operands, an 8-bit immediate and a four-bit operation code, and produces a 16-bit result and a write enable for the destination register. Both leave the block with no register in the path. A four-bit condition register holds negative, zero, overflow and carry. It is updated on the clock edge and feeds its carry back into the carry-chained operations.

The operations fall into two groups. The first takes two registers: add, add with carry, subtract, subtract with borrow, compare, compare with borrow, and two's-complement negate. The second adds or subtracts an 8-bit constant, placed either in the low byte or in the high byte of the word. The carry-chained operations and the low-byte immediate operations AND the new zero flag with the previous one. This lets a multi-word value be tested for zero one word at a time. The low-byte immediate forms use their own reduced overflow and carry rules.

Top module: `alu16_flagged`

## Requirements
- R1: Operation codes on `op_sel`: 0 add a+b, 1 add with carry a+b+C, 2 subtract a-b, 3 subtract with borrow a-b-C, 4 compare a-b, 5 compare with borrow a-b-C, 6 negate 0-b, 7 low-byte add a+imm, 8 high-byte add a+(imm<<8), 9 low-byte subtract a-imm, 10 high-byte subtract a-(imm<<8). All results are taken modulo 2^16 and appear on `result` in the same cycle.
- R2: `dest_we` is 1 for codes 0-3 and 6-10. It is 0 for the compare codes 4 and 5 and for the unused codes 11-15.
- R3: `flags` is {N,Z,V,C} on bits [3:0]. It is cleared to 0 on a rising clock edge while `rst_n` is low.
- R4: `flags` changes only on a rising edge where `flag_we` is 1 and the code is in the range 0-10. Otherwise it holds its value.
- R5: The new N is bit 15 of the result.
- R6: Codes 0, 1 and 8 (with y the second addend) set V when both addends share a sign bit that differs from the result's sign bit. They set C to the carry out of bit 15.
- R7: Codes 2, 3, 4, 5 and 10 (with y the subtrahend) set V when the sign bits of a and y differ and the result's sign bit differs from a. They set C to the borrow, that is, when a < y + carry-in.
- R8: Codes 1, 3, 5, 7 and 9 set the new Z to (result==0) AND the old Z. Every other valid code sets Z to (result==0) alone.
- R9: Code 7 sets V when a[15]=0 and result[15]=1, and sets C when a[15]=1 and result[15]=0. Code 9 sets V when a[15]=1 and result[15]=0, and sets C when a[15]=0 and result[15]=1.
- R10: Code 6 sets C when b is nonzero and sets V when b is 0x8000.
- R11: The carry-in used by codes 1, 3 and 5 is the registered C flag.
- R12: Codes 8 and 10 use the immediate shifted into bits [15:8], with zeros in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | First operand (destination register value for immediate forms) |
| opnd_b | input | 16 | Second operand |
| imm8 | input | 8 | Immediate constant |
| flag_we | input | 1 | Permits the flag update on this edge |
| result | output | 16 | Arithmetic result |
| dest_we | output | 1 | Destination register write enable |
| flags | output | 4 | Registered {N,Z,V,C} |

## Verification
The operand patterns are chosen to separate the flag rules from one another. Ordinary sums test the data path. 0x7FFF+1 tells the overflow rule apart from carry, and 0xFFFF+1 tells carry apart from zero. Small differences with a larger subtrahend exercise the borrow. A chained add and a chained compare that follow a result which is nonzero but yields zero show that Z is ANDed with its previous value and not taken from the result alone. Negation of 1 and of 0x8000 separates the negate overflow from its carry. Low-byte immediates that cross the sign boundary separate the reduced rules from the full-width ones. Directed steps show that a cleared `flag_we`, an unused code and a reset each act on the flags as required.

// File: rtl/alu16_pkg.sv
// Package: shared operation codes, flag classes and flag bit positions for
// the 16-bit add/subtract unit. Assumes a four-bit operation code.
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_CMP   = 4'd4,
        OP_CPC   = 4'd5,
        OP_NEG   = 4'd6,
        OP_ADDLO = 4'd7,
        OP_ADDHI = 4'd8,
        OP_SUBLO = 4'd9,
        OP_SUBHI = 4'd10
    } op_e;

    // Which overflow/carry rule applies to an operation.
    typedef enum logic [2:0] {
        FC_ADD,
        FC_SUB,
        FC_NEG,
        FC_ADDLO,
        FC_SUBLO
    } fcls_e;

    localparam int FLAG_W = 4;
    localparam int FLG_N  = 3;
    localparam int FLG_Z  = 2;
    localparam int FLG_V  = 1;
    localparam int FLG_C  = 0;

endpackage

// File: rtl/alu16_opnd_sel.sv
// Operand selector: decodes the operation code into the adder operands, the
// subtract direction, the carry-in, the flag rule and the write enables.
// Assumes WIDTH > IMM_W; the immediate is zero-extended into the low bits or
// shifted into the top bits.
module alu16_opnd_sel
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int IMM_W = 8
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             carry_q,
    output logic [WIDTH-1:0] x_op,
    output logic [WIDTH-1:0] y_op,
    output logic             is_sub,
    output logic             cin,
    output fcls_e            fcls,
    output logic             z_chain,
    output logic             dest_we,
    output logic             op_valid
);
    localparam int PAD_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] imm_lo;
    logic [WIDTH-1:0] imm_hi;

    assign imm_lo = {{PAD_W{1'b0}}, imm};
    assign imm_hi = {imm, {PAD_W{1'b0}}};

    // Decode the operation into operands and control.
    always_comb begin
        x_op     = opnd_a;
        y_op     = opnd_b;
        is_sub   = 1'b0;
        cin      = 1'b0;
        fcls     = FC_ADD;
        z_chain  = 1'b0;
        dest_we  = 1'b0;
        op_valid = 1'b1;
        case (op_e'(op_sel))
            OP_ADD: begin
                dest_we = 1'b1;
            end
            OP_ADC: begin
                cin     = carry_q;
                z_chain = 1'b1;
                dest_we = 1'b1;
            end
            OP_SUB: begin
                is_sub  = 1'b1;
                fcls    = FC_SUB;
                dest_we = 1'b1;
            end
            OP_SBC: begin
                is_sub  = 1'b1;
                cin     = carry_q;
                fcls    = FC_SUB;
                z_chain = 1'b1;
                dest_we = 1'b1;
            end
            OP_CMP: begin
                is_sub  = 1'b1;
                fcls    = FC_SUB;
            end
            OP_CPC: begin
                is_sub  = 1'b1;
                cin     = carry_q;
                fcls    = FC_SUB;
                z_chain = 1'b1;
            end
            OP_NEG: begin
                x_op    = '0;
                is_sub  = 1'b1;
                fcls    = FC_NEG;
                dest_we = 1'b1;
            end
            OP_ADDLO: begin
                y_op    = imm_lo;
                fcls    = FC_ADDLO;
                z_chain = 1'b1;
                dest_we = 1'b1;
            end
            OP_ADDHI: begin
                y_op    = imm_hi;
                dest_we = 1'b1;
            end
            OP_SUBLO: begin
                y_op    = imm_lo;
                is_sub  = 1'b1;
                fcls    = FC_SUBLO;
                z_chain = 1'b1;
                dest_we = 1'b1;
            end
            OP_SUBHI: begin
                y_op    = imm_hi;
                is_sub  = 1'b1;
                fcls    = FC_SUB;
                dest_we = 1'b1;
            end
            default: begin
                op_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu16_addsub_core.sv
// Adder core: one carry-propagate adder serving both directions. A subtract
// inverts y and the carry-in, so x - y - cin = x + ~y + (1 - cin).
// Assumes cin is a borrow when is_sub is set.
module alu16_addsub_core #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_op,
    input  logic [WIDTH-1:0] y_op,
    input  logic             is_sub,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] y_eff;
    logic             c_eff;

    // Condition the second operand and carry for the chosen direction.
    always_comb begin
        y_eff = is_sub ? ~y_op : y_op;
        c_eff = is_sub ? ~cin : cin;
    end

    // Single shared adder.
    always_comb begin
        sum = x_op + y_eff + {{(WIDTH-1){1'b0}}, c_eff};
    end

endmodule

// File: rtl/alu16_flag_eval.sv
// Flag evaluator: forms the next {N,Z,V,C} from the operands, the result and
// the flag rule chosen by the decoder. Assumes y is the operand before any
// inversion for subtraction.
module alu16_flag_eval
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  fcls_e             fcls,
    input  logic [WIDTH-1:0]  x_op,
    input  logic [WIDTH-1:0]  y_op,
    input  logic [WIDTH-1:0]  sum,
    input  logic              z_chain,
    input  logic              z_old,
    output logic [FLAG_W-1:0] flags_nxt
);
    localparam int MSB = WIDTH - 1;

    logic xs, ys, rs;
    logic v_bit, c_bit, z_bit;

    assign xs = x_op[MSB];
    assign ys = y_op[MSB];
    assign rs = sum[MSB];

    // Overflow and carry by flag rule, taken from the sign bits.
    always_comb begin
        case (fcls)
            FC_ADD: begin
                v_bit = (xs & ys & ~rs) | (~xs & ~ys & rs);
                c_bit = (xs & ys) | (ys & ~rs) | (~rs & xs);
            end
            FC_SUB: begin
                v_bit = (xs & ~ys & ~rs) | (~xs & ys & rs);
                c_bit = (~xs & ys) | (ys & rs) | (~xs & rs);
            end
            FC_NEG: begin
                v_bit = ys & rs;
                c_bit = ys | rs;
            end
            FC_ADDLO: begin
                v_bit = ~xs & rs;
                c_bit = xs & ~rs;
            end
            FC_SUBLO: begin
                v_bit = xs & ~rs;
                c_bit = ~xs & rs;
            end
            default: begin
                v_bit = 1'b0;
                c_bit = 1'b0;
            end
        endcase
    end

    // Zero flag, optionally chained with the previous one.
    always_comb begin
        z_bit = (sum == '0) & (~z_chain | z_old);
    end

    // Pack in {N,Z,V,C} order.
    always_comb begin
        flags_nxt        = '0;
        flags_nxt[FLG_N] = rs;
        flags_nxt[FLG_Z] = z_bit;
        flags_nxt[FLG_V] = v_bit;
        flags_nxt[FLG_C] = c_bit;
    end

endmodule

// File: rtl/alu16_flag_reg.sv
// Condition register: holds the flags, clears on synchronous active-low
// reset, loads only when enabled.
module alu16_flag_reg
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLAG_W-1:0] d,
    output logic [FLAG_W-1:0] q
);
    // Clear on reset, otherwise load when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu16_flagged.sv
// Top: 16-bit add/subtract unit with a registered condition code. Result and
// destination write enable are combinational; the flags are registered.
// Assumes register-file reads, including a zero register, are done upstream.
module alu16_flagged
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int IMM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [IMM_W-1:0]  imm8,
    input  logic              flag_we,
    output logic [WIDTH-1:0]  result,
    output logic              dest_we,
    output logic [FLAG_W-1:0] flags
);
    logic [WIDTH-1:0]  x_op;
    logic [WIDTH-1:0]  y_op;
    logic              is_sub;
    logic              cin;
    fcls_e             fcls;
    logic              z_chain;
    logic              op_valid;
    logic [FLAG_W-1:0] flags_nxt;
    logic              flag_load;

    alu16_opnd_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm      (imm8),
        .carry_q  (flags[FLG_C]),
        .x_op     (x_op),
        .y_op     (y_op),
        .is_sub   (is_sub),
        .cin      (cin),
        .fcls     (fcls),
        .z_chain  (z_chain),
        .dest_we  (dest_we),
        .op_valid (op_valid)
    );

    alu16_addsub_core #(.WIDTH(WIDTH)) u_core (
        .x_op   (x_op),
        .y_op   (y_op),
        .is_sub (is_sub),
        .cin    (cin),
        .sum    (result)
    );

    alu16_flag_eval #(.WIDTH(WIDTH)) u_eval (
        .fcls      (fcls),
        .x_op      (x_op),
        .y_op      (y_op),
        .sum       (result),
        .z_chain   (z_chain),
        .z_old     (flags[FLG_Z]),
        .flags_nxt (flags_nxt)
    );

    // Flags load only for a defined operation with the enable set.
    assign flag_load = flag_we & op_valid;

    alu16_flag_reg u_freg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .d     (flags_nxt),
        .q     (flags)
    );

endmodule

// File: rtl/alu16_flagged_chk.sv
// Checker: temporal properties on the ports of the add/subtract unit,
// attached by bind. Assumes the default 4-bit flag layout {N,Z,V,C}.
module alu16_flagged_chk #(
    parameter int WIDTH = 16,
    parameter int IMM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [IMM_W-1:0] imm8,
    input logic             flag_we,
    input logic [WIDTH-1:0] result,
    input logic             dest_we,
    input logic [3:0]       flags
);
    localparam int MSB = WIDTH - 1;

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd0) |-> (result == WIDTH'(opnd_a + opnd_b))); // R1

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd4 || op_sel == 4'd5) |-> !dest_we); // R2

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we || op_sel > 4'd10) |=> $stable(flags)); // R4

    AST_N_FROM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel <= 4'd10) |=> (flags[3] == $past(result[MSB]))); // R5

    AST_Z_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 4'd1 && !flags[2]) |=> !flags[2]); // R8

    AST_NEG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 4'd6) |=> (flags[0] == ($past(opnd_b) != '0))); // R10

    AST_IMM_HI_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd8) |-> (result[IMM_W-1:0] == opnd_a[IMM_W-1:0])); // R12

endmodule

bind alu16_flagged alu16_flagged_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .imm8    (imm8),
    .flag_we (flag_we),
    .result  (result),
    .dest_we (dest_we),
    .flags   (flags)
);

// File: tb/alu16_flagged_tb_top.sv
// Bench: table of operations walked in order, flags predicted by a model
// written from the requirements, then directed reset and corner steps.
module alu16_flagged_tb_top;
    localparam int CLK_P = 10;
    localparam int NVEC  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [7:0]  imm8 = '0;
    logic        flag_we = 1'b0;
    logic [15:0] result;
    logic        dest_we;
    logic [3:0]  flags;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] mflags = '0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    alu16_flagged dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .imm8    (imm8),
        .flag_we (flag_we),
        .result  (result),
        .dest_we (dest_we),
        .flags   (flags)
    );

    // {op, a, b, imm, expected result, expected dest_we}
    localparam logic [60:0] VEC [NVEC] = '{
        {4'd0,  16'h1234, 16'h1111, 8'h00, 16'h2345, 1'b1}, // R1 add
        {4'd0,  16'h7FFF, 16'h0001, 8'h00, 16'h8000, 1'b1}, // R6 overflow
        {4'd0,  16'hFFFF, 16'h0001, 8'h00, 16'h0000, 1'b1}, // R6 carry out
        {4'd1,  16'h0000, 16'h0000, 8'h00, 16'h0001, 1'b1}, // R11 carry in
        {4'd2,  16'h0005, 16'h0007, 8'h00, 16'hFFFE, 1'b1}, // R7 borrow
        {4'd3,  16'h0003, 16'h0001, 8'h00, 16'h0001, 1'b1}, // R11 borrow in
        {4'd4,  16'h8000, 16'h0001, 8'h00, 16'h7FFF, 1'b0}, // R2 compare
        {4'd5,  16'h0000, 16'h0000, 8'h00, 16'h0000, 1'b0}, // R8 chained Z
        {4'd6,  16'h0000, 16'h0001, 8'h00, 16'hFFFF, 1'b1}, // R10 negate
        {4'd6,  16'h0000, 16'h8000, 8'h00, 16'h8000, 1'b1}, // R10 most negative
        {4'd7,  16'h12FF, 16'h0000, 8'h01, 16'h1300, 1'b1}, // R9 low add
        {4'd8,  16'h1234, 16'h0000, 8'h80, 16'h9234, 1'b1}, // R12 high add
        {4'd9,  16'h0100, 16'h0000, 8'h01, 16'h00FF, 1'b1}, // R9 low sub
        {4'd10, 16'h0100, 16'h0000, 8'h02, 16'hFF00, 1'b1}, // R12 high sub
        {4'd0,  16'h0000, 16'h0000, 8'h00, 16'h0000, 1'b1}  // R5 zero result
    };

    // Expected flags from the requirements, written with wide arithmetic.
    function automatic logic [3:0] model(input logic [3:0] op, input logic [15:0] a,
                                         input logic [15:0] b, input logic [7:0] im,
                                         input logic [3:0] old);
        logic [16:0] w;
        logic [15:0] r;
        logic [15:0] y;
        logic ci, z, v, c;
        ci = old[0];
        case (op)
            4'd0, 4'd1, 4'd8: begin
                y = (op == 4'd8) ? {im, 8'h00} : b;
                w = {1'b0, a} + {1'b0, y} + {16'd0, (op == 4'd1) ? ci : 1'b0};
                r = w[15:0];
                c = w[16];
                v = (a[15] == y[15]) && (r[15] != a[15]);
            end
            4'd2, 4'd3, 4'd4, 4'd5, 4'd10: begin
                y = (op == 4'd10) ? {im, 8'h00} : b;
                w = {16'd0, (op == 4'd3 || op == 4'd5) ? ci : 1'b0};
                r = a - y - w[15:0];
                c = ({1'b0, a} < ({1'b0, y} + w));
                v = (a[15] != y[15]) && (r[15] != a[15]);
            end
            4'd6: begin
                r = 16'd0 - b;
                c = (b != 16'd0);
                v = (b == 16'h8000);
            end
            4'd7: begin
                r = a + {8'h00, im};
                v = !a[15] && r[15];
                c = a[15] && !r[15];
            end
            4'd9: begin
                r = a - {8'h00, im};
                v = a[15] && !r[15];
                c = !a[15] && r[15];
            end
            default: return old;
        endcase
        z = (r == 16'd0);
        if (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd7 || op == 4'd9)
            z = z && old[2];
        return {r[15], z, v, c};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check outputs, then flags.
    task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] im, input logic we, input logic chk_r,
                         input logic [15:0] exp_r, input logic exp_we, input string req);
        logic [3:0] nf;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm8 = im; flag_we = we;
        #1;
        if (chk_r) check(req, "result", result, exp_r);
        check(req, "dest_we", {15'd0, dest_we}, {15'd0, exp_we});
        nf = we ? model(op, a, b, im, mflags) : mflags;
        @(posedge clk);
        #(CLK_P/4);
        mflags = nf;
        check(req, "flags", {12'd0, flags}, {12'd0, mflags});
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        check("R3", "reset flags", {12'd0, flags}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Table walk: R1 R2 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][60:57], VEC[i][56:41], VEC[i][40:25], VEC[i][24:17], 1'b1,
                  1'b1, VEC[i][16:1], VEC[i][0], "R1/table");
        end
        // R4: enable low leaves flags alone
        apply(4'd0, 16'h7FFF, 16'h0001, 8'h00, 1'b0, 1'b1, 16'h8000, 1'b1, "R4");
        // R4 and R2: unused code writes nothing
        apply(4'd12, 16'hFFFF, 16'h0001, 8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, "R4");
        // R3: synchronous reset clears flags
        apply(4'd2, 16'h0000, 16'h0001, 8'h00, 1'b1, 1'b1, 16'hFFFF, 1'b1, "R7");
        @(negedge clk);
        rst_n = 1'b0; flag_we = 1'b0;
        @(posedge clk);
        #(CLK_P/4);
        mflags = '0;
        check("R3", "flags after reset", {12'd0, flags}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: zero result does not raise Z when old Z is clear
        apply(4'd1, 16'h0000, 16'h0000, 8'h00, 1'b1, 1'b1, 16'h0000, 1'b1, "R8");
        check("R8", "Z stays clear", {15'd0, flags[2]}, 16'd0);
        apply(4'd0, 16'h0000, 16'h0000, 8'h00, 1'b1, 1'b1, 16'h0000, 1'b1, "R8");
        apply(4'd1, 16'h0000, 16'h0000, 8'h00, 1'b1, 1'b1, 16'h0000, 1'b1, "R8");
        check("R8", "Z kept set", {15'd0, flags[2]}, 16'd1);
        // R9: low add crossing into negative
        apply(4'd7, 16'h7FFF, 16'h0000, 8'h01, 1'b1, 1'b1, 16'h8000, 1'b1, "R9");
        check("R9", "V set", {15'd0, flags[1]}, 16'd1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule